// File: doc/BRIEF.md
# Calibration Pulse Trigger Gate

This block decides the moment at which a calibration pulser fires. It watches two mode bits from the timing system, a fast gate and an external enable. A calibration event is the onset of a coincidence: the mode bits must show calibration while the gate and the enable are both high. After each accepted event the block counts a programmable delay, so that the pulse can be lined up with the later readout accept. It then drives an active-low trigger line low for a fixed pulse width. The pulser acts on the falling edge of that line.

The block also enforces a minimum spacing between pulses. This holdoff caps the repetition rate at about 1 kHz when the clock runs at 10 MHz. A veto input, such as a noise blanking signal, suppresses pulsing. Every event that the block discards, whether for the holdoff, an in-flight pulse or the veto, produces a one-cycle drop strobe.

All five asynchronous inputs pass through two-flop synchronisers before any logic uses them. The delay setting is a static configuration input. It is not synchronised.

Top module: `cal_trig_gate`

## Requirements
- R1: After reset `trig_n_o` is high and `drop_o` is low, and they stay that way until an event is accepted or dropped.
- R2: An event needs `mb_i[0]`=1 and `mb_i[1]`=0. Any other mode pattern produces no pulse.
- R3: An event needs `gate_i` and `ext_en_i` high together. Only the rising edge of that coincidence counts, so a held coincidence gives one event.
- R4: With delay setting D on `delay_i`, `trig_n_o` falls on the (D+4)th rising clock edge after the inputs complete the coincidence. This holds for D from 0 to 4095.
- R5: Once `trig_n_o` falls, it stays low for exactly PULSE_W cycles (200 by default) and then returns high.
- R6: An event is accepted only if at least HOLDOFF cycles (10000 by default) have passed since the previous falling edge of `trig_n_o`. An earlier event is dropped and gives no pulse.
- R7: If the synchronised veto is high on any cycle of the delay, the pending pulse is cancelled and `drop_o` pulses high for one cycle.
- R8: An event that arrives while the synchronised veto is high is dropped, with a `drop_o` strobe and no pulse.
- R9: A veto that arrives during the low phase does not shorten the pulse.
- R10: An event that arrives while a pulse is pending or active is dropped. The pending pulse keeps its original timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock (10 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_i | input | 2 | Calibration mode bits: [0] must be 1 and [1] must be 0 (asynchronous) |
| gate_i | input | 1 | Fast gate from the timing receiver (asynchronous) |
| ext_en_i | input | 1 | External enable (asynchronous) |
| veto_i | input | 1 | Pulse veto, active high (asynchronous) |
| delay_i | input | 12 | Delay in clock cycles from event to trigger (static) |
| trig_n_o | output | 1 | Active-low pulse trigger; the pulser uses its falling edge |
| drop_o | output | 1 | One-cycle strobe for each discarded event |

## Verification
The assertions check several rules on every cycle. The low phase is entered only from a delay that has run out, and the holdoff has expired whenever a delay starts. A veto during the delay always cancels it and raises the drop strobe, while a veto during the low phase never cuts the pulse short. Each run of low cycles has exactly the configured width, and the event detector never fires on two cycles in a row. Only the bench scenarios show the end-to-end results. These are the exact input-to-trigger latency through the synchronisers, the rejection of wrong mode patterns and half coincidences, and the accounting of dropped events. They also cover the timing of a pulse that survives a second onset during its delay.

// File: rtl/cal_trig_pkg.sv
package cal_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIRE = 2'd2
  } fire_state_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= d_i[b];
          stab_q <= meta_q;
        end
      end
      assign q_o[b] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/cal_event_detect.sv
module cal_event_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mb_s,
  input  logic       gate_s,
  input  logic       en_s,
  output logic       evt_o
);

  logic cal_ok;
  logic cal_q;

  assign cal_ok = mb_s[0] & ~mb_s[1] & gate_s & en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= 1'b0;
    else        cal_q <= cal_ok;
  end

  assign evt_o = cal_ok & ~cal_q;

  // R3
  onset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

endmodule

// File: rtl/cal_fire_seq.sv
module cal_fire_seq
  import cal_trig_pkg::*;
#(
  parameter int unsigned DLY_W   = 12,
  parameter int unsigned PULSE_W = 200,
  parameter int unsigned HOLDOFF = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             veto_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             trig_n_o,
  output logic             drop_o
);

  localparam int unsigned PW_W = $clog2(PULSE_W + 1);
  localparam int unsigned HO_W = $clog2(HOLDOFF + 1);

  fire_state_e      st_q, st_n;
  logic [DLY_W-1:0] dly_q, dly_n;
  logic [PW_W-1:0]  pw_q, pw_n;
  logic [HO_W-1:0]  ho_q, ho_n;
  logic             drop_q, drop_n;

  always_comb begin
    st_n   = st_q;
    dly_n  = dly_q;
    pw_n   = pw_q;
    ho_n   = (ho_q != '0) ? ho_q - 1'b1 : '0;
    drop_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (evt_i) begin
          if (!veto_i && ho_q == '0) begin
            st_n  = ST_WAIT;
            dly_n = delay_i;
          end else begin
            drop_n = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (evt_i) drop_n = 1'b1;
        if (veto_i) begin
          st_n   = ST_IDLE;
          drop_n = 1'b1;
        end else if (dly_q == '0) begin
          st_n = ST_FIRE;
          pw_n = PW_W'(PULSE_W - 1);
          ho_n = HO_W'(HOLDOFF - 1);
        end else begin
          dly_n = dly_q - 1'b1;
        end
      end
      ST_FIRE: begin
        if (evt_i) drop_n = 1'b1;
        if (pw_q == '0) st_n = ST_IDLE;
        else            pw_n = pw_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dly_q  <= '0;
      pw_q   <= '0;
      ho_q   <= '0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      dly_q  <= dly_n;
      pw_q   <= pw_n;
      ho_q   <= ho_n;
      drop_q <= drop_n;
    end
  end

  assign trig_n_o = (st_q != ST_FIRE);
  assign drop_o   = drop_q;

  logic [PW_W:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run_q <= '0;
    else if (st_q == ST_FIRE) low_run_q <= low_run_q + 1'b1;
    else                     low_run_q <= '0;
  end

  // R4
  fire_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIRE && $past(st_q) != ST_FIRE) |->
      ($past(st_q) == ST_WAIT && $past(dly_q) == '0));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_FIRE && st_q != ST_FIRE) |->
      low_run_q == (PW_W + 1)'(PULSE_W));

  // R6
  holdoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) == ST_IDLE) |-> $past(ho_q) == '0);

  // R7
  veto_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_WAIT && $past(veto_i)) |-> (st_q == ST_IDLE && drop_o));

  // R9
  veto_no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_FIRE && $past(pw_q) != '0) |-> st_q == ST_FIRE);

endmodule

// File: rtl/cal_trig_gate.sv
module cal_trig_gate #(
  parameter int unsigned DLY_W   = 12,
  parameter int unsigned PULSE_W = 200,
  parameter int unsigned HOLDOFF = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mb_i,
  input  logic             gate_i,
  input  logic             ext_en_i,
  input  logic             veto_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             trig_n_o,
  output logic             drop_o
);

  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw, synced;
  logic             evt;

  assign raw = {veto_i, ext_en_i, gate_i, mb_i};

  cal_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (synced)
  );

  cal_event_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .mb_s   (synced[1:0]),
    .gate_s (synced[2]),
    .en_s   (synced[3]),
    .evt_o  (evt)
  );

  cal_fire_seq #(
    .DLY_W   (DLY_W),
    .PULSE_W (PULSE_W),
    .HOLDOFF (HOLDOFF)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .veto_i   (synced[4]),
    .delay_i  (delay_i),
    .trig_n_o (trig_n_o),
    .drop_o   (drop_o)
  );

endmodule

// File: tb/test_cal_trig_gate.sv
module test_cal_trig_gate;

  localparam int PW = 200;
  localparam int HO = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mb = 2'b01;
  logic gate = 1'b0, ext_en = 1'b1, veto = 1'b0;
  logic [11:0] delay = 12'd5;
  logic trig_n, drop;

  always #10 clk = ~clk;

  cal_trig_gate i_cal_trig_gate (
    .clk(clk), .rst_n(rst_n), .mb_i(mb), .gate_i(gate), .ext_en_i(ext_en),
    .veto_i(veto), .delay_i(delay), .trig_n_o(trig_n), .drop_o(drop)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Behavioural reference: event times and windows as integers.
  logic [4:0] m_s1, m_s2;
  bit m_prev, m_pend, m_trig_n, m_drop;
  longint cyc, fire_at, last_fall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = 0; m_pend = 0;
      m_trig_n = 1; m_drop = 0; cyc = 0; fire_at = 0; last_fall = -100000;
    end else begin
      bit calm, vt, ev, dr;
      calm = m_s2[0] & ~m_s2[1] & m_s2[2] & m_s2[3];
      vt = m_s2[4];
      ev = calm & !m_prev;
      dr = 0;
      if (m_pend) begin
        if (ev) dr = 1;
        if (vt) begin m_pend = 0; dr = 1; end
        else if (cyc == fire_at) begin m_pend = 0; last_fall = cyc; end
      end else if (ev) begin
        if (!vt && cyc >= last_fall + HO) begin
          m_pend = 1; fire_at = cyc + 1 + delay;
        end else dr = 1;
      end
      m_trig_n = !(cyc >= last_fall && cyc <= last_fall + PW - 1);
      m_drop = dr;
      m_prev = calm;
      m_s2 = m_s1;
      m_s1 = {veto, ext_en, gate, mb};
      cyc++;
    end
  end

  int pulses = 0, drops = 0;
  logic prev_trig = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R4 R5 R6 R7 R8 R9 R10 cycle compare
      chk(trig_n === m_trig_n, "R5 R6 trig_n_o vs model", int'(trig_n), int'(m_trig_n));
      chk(drop === m_drop, "R7 R8 R10 drop_o vs model", int'(drop), int'(m_drop));
      if (prev_trig && !trig_n) pulses++;
      if (drop) drops++;
      prev_trig = trig_n;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic onset_measure(input int d, output int lat, output int w);
    delay = 12'(d);
    @(negedge clk);
    gate = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (trig_n && lat < 6000);
    w = 0;
    while (!trig_n && w < 1000) begin @(negedge clk); w++; end
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int lat, w, p0, d0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(trig_n === 1'b1, "R1 trig_n_o after reset", int'(trig_n), 1);
    chk(drop === 1'b0, "R1 drop_o after reset", int'(drop), 0);

    // R4 R5 basic pulse, held coincidence gives one event (R3)
    p0 = pulses;
    onset_measure(5, lat, w);
    chk(lat == 9, "R4 latency D=5", lat, 9);
    chk(w == PW, "R5 width", w, PW);
    idle(HO + 200);
    chk(pulses - p0 == 1, "R3 held coincidence single pulse", pulses - p0, 1);
    gate = 1'b0; idle(10);

    // R2 wrong mode patterns
    p0 = pulses;
    mb = 2'b11; gate = 1'b1; idle(300); gate = 1'b0; idle(10);
    mb = 2'b00; gate = 1'b1; idle(300); gate = 1'b0; idle(10);
    mb = 2'b10; gate = 1'b1; idle(300); gate = 1'b0; idle(10);
    mb = 2'b01;
    chk(pulses == p0, "R2 non-calibration modes", pulses - p0, 0);

    // R3 half coincidences
    ext_en = 1'b0; gate = 1'b1; idle(300); gate = 1'b0; idle(10);
    ext_en = 1'b1; idle(300); ext_en = 1'b0; idle(10);
    chk(pulses == p0, "R3 gate or enable alone", pulses - p0, 0);
    ext_en = 1'b1; idle(10);

    // R6 retrigger inside holdoff dropped, later accepted
    onset_measure(5, lat, w);
    gate = 1'b0; idle(300);
    p0 = pulses; d0 = drops;
    gate = 1'b1; idle(300); gate = 1'b0;
    chk(pulses == p0, "R6 early event no pulse", pulses - p0, 0);
    chk(drops - d0 == 1, "R6 early event dropped", drops - d0, 1);
    idle(HO);
    onset_measure(5, lat, w);
    chk(lat == 9, "R6 accepted after holdoff", lat, 9);
    gate = 1'b0; idle(HO + 10);

    // R7 veto during delay cancels
    p0 = pulses; d0 = drops;
    delay = 12'd100;
    @(negedge clk); gate = 1'b1;
    idle(20); veto = 1'b1; idle(10); veto = 1'b0;
    idle(300);
    chk(pulses == p0, "R7 cancelled pulse", pulses - p0, 0);
    chk(drops - d0 == 1, "R7 cancel drop strobe", drops - d0, 1);
    gate = 1'b0; idle(10);

    // R8 veto at onset
    veto = 1'b1; idle(5);
    p0 = pulses; d0 = drops;
    gate = 1'b1; idle(300);
    chk(pulses == p0, "R8 vetoed onset no pulse", pulses - p0, 0);
    chk(drops - d0 == 1, "R8 vetoed onset dropped", drops - d0, 1);
    gate = 1'b0; veto = 1'b0; idle(10);

    // R9 veto during low phase
    delay = 12'd5;
    @(negedge clk); gate = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (trig_n && lat < 6000);
    veto = 1'b1;
    w = 0;
    while (!trig_n && w < 1000) begin @(negedge clk); w++; end
    veto = 1'b0;
    chk(w == PW, "R9 width under veto", w, PW);
    gate = 1'b0; idle(HO + 10);

    // R10 second onset during delay
    d0 = drops;
    delay = 12'd200;
    @(negedge clk); gate = 1'b1;
    lat = 0;
    repeat (20) begin @(negedge clk); lat++; end
    gate = 1'b0;
    repeat (5) begin @(negedge clk); lat++; end
    gate = 1'b1;
    do begin @(negedge clk); lat++; end while (trig_n && lat < 6000);
    chk(lat == 204, "R10 pending pulse timing kept", lat, 204);
    chk(drops - d0 == 1, "R10 second onset dropped", drops - d0, 1);
    gate = 1'b0; idle(HO + 10);

    // R4 delay extremes
    onset_measure(0, lat, w);
    chk(lat == 4, "R4 latency D=0", lat, 4);
    gate = 1'b0; idle(HO + 10);
    onset_measure(4095, lat, w);
    chk(lat == 4099, "R4 latency D=4095", lat, 4099);
    chk(w == PW, "R5 width after long delay", w, PW);
    gate = 1'b0; idle(20);

    finish_run();
  end

endmodule